// File: doc/BRIEF.md
# Serial Programming Command Engine

This block runs single transactions on a two-wire programming link made of one clock pin and one bidirectional data pin. A requester hands over a 4-bit command code, a 16-bit operand and a transaction kind. The engine clocks the command out, pauses, and then finishes in one of three ways. A write sends the operand. A read sends eight dummy zero bits, hands the data line to the target and clocks a byte back. A program-start sends the operand, three zero bits and one long clock-high hold that times the flash write, then a trailing field of sixteen zeros.

All pauses are counted in system clock cycles. One microsecond is `CYCLES_PER_US` cycles, and the programming hold is a separate parameter, `PROG_HOLD_CYCLES`, so a test can shorten it. Each bit is `HALF_CYCLES` cycles with the clock high, then `HALF_CYCLES` cycles with the clock low. Data out changes only at the start of a bit, and read data is sampled at the end of the low half. Power-up, key entry, erase loops and block loops belong to the layer above.

Top module: `pgm_cmd_engine`

## Requirements
- R1: After a request is accepted, the 4 command bits leave LSB first. Each bit holds the data pin steady while the clock pin is high for HALF_CYCLES cycles and then low for HALF_CYCLES cycles. Bits within a field follow each other with no extra spacing.
- R2: A write (kind 0) or program-start (kind 2) sends the 16-bit operand as one continuous LSB-first field, so the low byte goes before the high byte. Kind 3 is handled exactly like a write.
- R3: Between the last command bit and the first bit of the next field, the clock stays low for HALF_CYCLES + CYCLES_PER_US cycles. After the final field of a transaction there is a further gap of CYCLES_PER_US cycles.
- R4: A read (kind 1) sends 8 zero bits after the command, waits CYCLES_PER_US cycles, then drops the output enable for 8 clock pulses. The enable returns only after a further CYCLES_PER_US cycles, so it is low for 16*HALF_CYCLES + CYCLES_PER_US cycles. The enable is never low for any other kind.
- R5: A read samples `pin_dat_in` at the end of each low half and assembles the byte LSB first. `rd_data` carries that byte while `rd_valid` is high for exactly one cycle. `rd_valid` is never asserted by other kinds.
- R6: A program-start sends 3 zero bits after the operand. The clock then stays high for PROG_HOLD_CYCLES cycles with the data pin driven low, stays low for CYCLES_PER_US cycles, and finally 16 zero bits go out.
- R7: `req_ready` is high only while the engine is idle and `tgt_ready` is high. After acceptance it stays low for exactly the transaction length. That length is 40*HALF_CYCLES + 2*CYCLES_PER_US for a write, 40*HALF_CYCLES + 3*CYCLES_PER_US for a read, and 78*HALF_CYCLES + PROG_HOLD_CYCLES + 3*CYCLES_PER_US for a program-start.
- R8: While `tgt_ready` is low, a pending request is not accepted and the pins stay idle.
- R9: After reset the clock pin is low, the data pin is driven low with the enable high, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_ready | input | 1 | Target is ready to take commands |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_kind | input | 2 | 0 write, 1 read, 2 program-start, 3 same as write |
| req_cmd | input | 4 | Command code to shift out |
| req_operand | input | 16 | Operand for write and program-start |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| pin_clk | output | 1 | Programming clock pin |
| pin_dat_out | output | 1 | Data pin output value |
| pin_dat_oe | output | 1 | Data pin output enable (low while the target drives) |
| pin_dat_in | input | 1 | Data pin input value |

## Verification
Two things can happen in the same cycle. The final gap of one transaction can expire, and the idle state can take a new request. The bench provokes this by raising the next request in the very cycle `req_ready` returns, across every kind pairing. It then judges that the clock stayed low for exactly HALF_CYCLES + CYCLES_PER_US + 1 cycles between transactions, and that the new transaction's bits and length are unchanged. The other collision is `tgt_ready` falling while a request is already waiting. The bench holds a valid request against a low `tgt_ready` and checks that nothing is accepted and that no clock edge appears.

// File: rtl/pgm_cmd_pkg.sv
package pgm_cmd_pkg;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_PROG  = 2'd2,
    KIND_ALT   = 2'd3
  } req_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_GAP_OP, ST_OPER, ST_DUMMY, ST_TURN,
    ST_RECV, ST_PZERO, ST_HOLD, ST_SETTLE, ST_TAIL, ST_GAP_END
  } eng_state_e;

  localparam int CMD_BITS   = 4;
  localparam int OPER_BITS  = 16;
  localparam int DUMMY_BITS = 8;
  localparam int RX_BITS    = 8;
  localparam int PZERO_BITS = 3;
  localparam int TAIL_BITS  = 16;

  // cycles taken by a shifted field of nbits
  function automatic int field_cycles(int nbits, int half);
    return 2 * nbits * half;
  endfunction

  // cycles from acceptance until the engine is idle again
  function automatic int txn_cycles(logic [1:0] kind, int half, int cpu, int hold);
    case (kind)
      2'd1:    return field_cycles(CMD_BITS + DUMMY_BITS + RX_BITS, half) + 3 * cpu;
      2'd2:    return field_cycles(CMD_BITS + OPER_BITS + PZERO_BITS + TAIL_BITS, half)
                      + hold + 3 * cpu;
      default: return field_cycles(CMD_BITS + OPER_BITS, half) + 2 * cpu;
    endcase
  endfunction

endpackage

// File: rtl/pgm_gap_timer.sv
module pgm_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  output logic         running,
  output logic         done
);

  logic [W-1:0] cnt;

  assign done = running && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= load;
    end else if (running) begin
      if (cnt == W'(1)) running <= 1'b0;
      cnt <= cnt - W'(1);
    end
  end

  // R3: a zero-length gap would never expire
  assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (load != '0));

endmodule

// File: rtl/pgm_bit_shifter.sv
module pgm_bit_shifter #(
  parameter int HALF_CYCLES = 2,
  parameter int MAX_BITS    = 16,
  parameter int RX_W        = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(MAX_BITS+1)-1:0] nbits,
  input  logic [MAX_BITS-1:0]          word,
  input  logic                         capture,
  input  logic                         line_in,
  output logic                         busy,
  output logic                         done,
  output logic                         bit_clk,
  output logic                         bit_dat,
  output logic [RX_W-1:0]              rx_byte
);

  localparam int BW = $clog2(MAX_BITS + 1);
  localparam int HW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  logic                phase_hi;
  logic [HW-1:0]       tick;
  logic [BW-1:0]       left;
  logic [MAX_BITS-1:0] shreg;
  logic                cap_q;
  logic                tick_end;

  assign tick_end = (tick == HW'(HALF_CYCLES - 1));
  assign done     = busy && tick_end && !phase_hi && (left == BW'(1));
  assign bit_clk  = busy && phase_hi;
  assign bit_dat  = busy && !cap_q && shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase_hi <= 1'b0;
      tick     <= '0;
      left     <= '0;
      shreg    <= '0;
      cap_q    <= 1'b0;
      rx_byte  <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      phase_hi <= 1'b1;
      tick     <= '0;
      left     <= nbits;
      shreg    <= word;
      cap_q    <= capture;
    end else if (busy) begin
      if (tick_end) begin
        tick <= '0;
        if (phase_hi) begin
          phase_hi <= 1'b0;
        end else begin
          if (cap_q) rx_byte <= {line_in, rx_byte[RX_W-1:1]};
          shreg <= shreg >> 1;
          left  <= left - BW'(1);
          if (left == BW'(1)) busy <= 1'b0;
          else                phase_hi <= 1'b1;
        end
      end else begin
        tick <= tick + HW'(1);
      end
    end
  end

  // R1: a new field never starts on top of an unfinished one
  assert_no_field_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy || done));

  // R1: a running field always has bits left
  assert_bits_remaining_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left != '0));

endmodule

// File: rtl/pgm_cmd_engine.sv
module pgm_cmd_engine
  import pgm_cmd_pkg::*;
#(
  parameter int CYCLES_PER_US    = 4,
  parameter int HALF_CYCLES      = 2,
  parameter int PROG_HOLD_CYCLES = 4800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tgt_ready,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [3:0]  req_cmd,
  input  logic [15:0] req_operand,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        pin_clk,
  output logic        pin_dat_out,
  output logic        pin_dat_oe,
  input  logic        pin_dat_in
);

  localparam int TMAX = (CYCLES_PER_US > PROG_HOLD_CYCLES) ? CYCLES_PER_US : PROG_HOLD_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(OPER_BITS + 1);

  eng_state_e     state, state_d;
  req_kind_e      kind_q;
  logic [15:0]    op_q;

  // named internal events
  logic           accept;
  logic           field_done;
  logic           gap_done;
  logic           sh_start, sh_cap, sh_busy, sh_clk, sh_dat;
  logic [BW-1:0]  sh_nbits;
  logic [15:0]    sh_word;
  logic           tm_start, tm_running;
  logic [TW-1:0]  tm_load;
  logic [7:0]     rx_byte;
  int             busy_cnt;

  assign req_ready = (state == ST_IDLE) && tgt_ready;
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d  = state;
    sh_start = 1'b0;
    sh_word  = '0;
    sh_nbits = '0;
    sh_cap   = 1'b0;
    tm_start = 1'b0;
    tm_load  = TW'(CYCLES_PER_US);
    case (state)
      ST_IDLE: if (accept) begin
        state_d  = ST_CMD;
        sh_start = 1'b1;
        sh_word  = {12'b0, req_cmd};
        sh_nbits = BW'(CMD_BITS);
      end
      ST_CMD: if (field_done) begin
        state_d  = ST_GAP_OP;
        tm_start = 1'b1;
      end
      ST_GAP_OP: if (gap_done) begin
        sh_start = 1'b1;
        if (kind_q == KIND_READ) begin
          state_d  = ST_DUMMY;
          sh_nbits = BW'(DUMMY_BITS);
        end else begin
          state_d  = ST_OPER;
          sh_word  = op_q;
          sh_nbits = BW'(OPER_BITS);
        end
      end
      ST_OPER: if (field_done) begin
        if (kind_q == KIND_PROG) begin
          state_d  = ST_PZERO;
          sh_start = 1'b1;
          sh_nbits = BW'(PZERO_BITS);
        end else begin
          state_d  = ST_GAP_END;
          tm_start = 1'b1;
        end
      end
      ST_DUMMY: if (field_done) begin
        state_d  = ST_TURN;
        tm_start = 1'b1;
      end
      ST_TURN: if (gap_done) begin
        state_d  = ST_RECV;
        sh_start = 1'b1;
        sh_cap   = 1'b1;
        sh_nbits = BW'(RX_BITS);
      end
      ST_RECV: if (field_done) begin
        state_d  = ST_GAP_END;
        tm_start = 1'b1;
      end
      ST_PZERO: if (field_done) begin
        state_d  = ST_HOLD;
        tm_start = 1'b1;
        tm_load  = TW'(PROG_HOLD_CYCLES);
      end
      ST_HOLD: if (gap_done) begin
        state_d  = ST_SETTLE;
        tm_start = 1'b1;
      end
      ST_SETTLE: if (gap_done) begin
        state_d  = ST_TAIL;
        sh_start = 1'b1;
        sh_nbits = BW'(TAIL_BITS);
      end
      ST_TAIL: if (field_done) begin
        state_d  = ST_GAP_END;
        tm_start = 1'b1;
      end
      ST_GAP_END: if (gap_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_q   <= KIND_WRITE;
      op_q     <= '0;
      rd_valid <= 1'b0;
      busy_cnt <= 0;
    end else begin
      state    <= state_d;
      rd_valid <= (state == ST_RECV) && field_done;
      if (accept) begin
        kind_q   <= req_kind_e'(req_kind);
        op_q     <= req_operand;
        busy_cnt <= 1;
      end else if (state != ST_IDLE) begin
        busy_cnt <= busy_cnt + 1;
      end
    end
  end

  pgm_bit_shifter #(
    .HALF_CYCLES(HALF_CYCLES),
    .MAX_BITS   (OPER_BITS),
    .RX_W       (RX_BITS)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sh_start),
    .nbits  (sh_nbits),
    .word   (sh_word),
    .capture(sh_cap),
    .line_in(pin_dat_in),
    .busy   (sh_busy),
    .done   (field_done),
    .bit_clk(sh_clk),
    .bit_dat(sh_dat),
    .rx_byte(rx_byte)
  );

  pgm_gap_timer #(.W(TW)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tm_start),
    .load   (tm_load),
    .running(tm_running),
    .done   (gap_done)
  );

  assign rd_data     = rx_byte;
  assign pin_clk     = sh_clk || (state == ST_HOLD);
  assign pin_dat_out = sh_dat;
  assign pin_dat_oe  = !((state == ST_RECV) || ((state == ST_GAP_END) && (kind_q == KIND_READ)));

  // R7: acceptance closes the request port on the next cycle
  assert_accept_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7: the busy span matches the arithmetic length for the kind
  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_GAP_END) && gap_done) |->
      (busy_cnt == txn_cycles(kind_q, HALF_CYCLES, CYCLES_PER_US, PROG_HOLD_CYCLES)));

  // R4: the data line is only released inside a read
  assert_release_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_dat_oe |-> (kind_q == KIND_READ));

  // R5: the read strobe lasts one cycle
  assert_rd_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R5: the read strobe belongs to a read in its closing gap
  assert_rd_valid_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((kind_q == KIND_READ) && (state == ST_GAP_END)));

  // R6: during the programming hold the clock is high and data driven low
  assert_hold_drives_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> (pin_clk && pin_dat_oe && !pin_dat_out && tm_running));

  // R9: idle pins are quiet and driven
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!pin_clk && pin_dat_oe && !sh_busy));

endmodule

// File: tb/pgm_cmd_engine_test.sv
`timescale 1ns/1ps
module pgm_cmd_engine_test;

  localparam int C = 3;
  localparam int H = 2;
  localparam int P = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tgt_ready = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [3:0] req_cmd = 4'd0;
  logic [15:0] req_operand = 16'd0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic pin_clk, pin_dat_out, pin_dat_oe;
  logic pin_dat_in = 1'b0;

  always #2.5 clk = ~clk;

  pgm_cmd_engine #(
    .CYCLES_PER_US(C), .HALF_CYCLES(H), .PROG_HOLD_CYCLES(P)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tgt_ready(tgt_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_cmd(req_cmd), .req_operand(req_operand), .rd_data(rd_data),
    .rd_valid(rd_valid), .pin_clk(pin_clk), .pin_dat_out(pin_dat_out),
    .pin_dat_oe(pin_dat_oe), .pin_dat_in(pin_dat_in)
  );

  int checks = 0;
  int fails = 0;

  // pin monitor, acting as the target
  int rec_bit[64];
  int rec_oe[64];
  int rec_lo[64];
  int rec_hi[64];
  int npulse = 0;
  int lo_cnt = 0;
  int hi_cnt = 0;
  logic prev_clk = 1'b0;
  int oe_lo = 0;
  int oe_len = 0;
  int rdv_cnt = 0;
  logic [7:0] rdv_data = 8'd0;
  logic [7:0] tgt_byte = 8'd0;
  int rx_idx = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pin_clk && !prev_clk) begin
        if (npulse < 64) begin
          rec_bit[npulse] = pin_dat_out;
          rec_oe[npulse]  = pin_dat_oe;
          rec_lo[npulse]  = lo_cnt;
        end
        npulse = npulse + 1;
        hi_cnt = 1;
        if (!pin_dat_oe && rx_idx < 8) begin
          pin_dat_in = tgt_byte[rx_idx];
          rx_idx = rx_idx + 1;
        end
      end else if (!pin_clk && prev_clk) begin
        if (npulse > 0 && npulse <= 64) rec_hi[npulse-1] = hi_cnt;
        lo_cnt = 1;
      end else if (pin_clk) begin
        hi_cnt = hi_cnt + 1;
      end else begin
        lo_cnt = lo_cnt + 1;
      end
      prev_clk = pin_clk;
      if (!pin_dat_oe) oe_lo = oe_lo + 1;
      else if (oe_lo != 0) begin
        oe_len = oe_lo;
        oe_lo = 0;
      end
      if (rd_valid) begin
        rdv_cnt = rdv_cnt + 1;
        rdv_data = rd_data;
      end
    end
  end

  // expected pulse list
  int exp_bit[64];
  int exp_lo[64];
  int exp_hi[64];
  int exp_oe[64];
  int nexp;

  task automatic push(int b, int lo, int hi, int oe);
    exp_bit[nexp] = b; exp_lo[nexp] = lo; exp_hi[nexp] = hi; exp_oe[nexp] = oe;
    nexp = nexp + 1;
  endtask

  task automatic build_exp(int kind, logic [3:0] cmd, logic [15:0] op);
    nexp = 0;
    for (int i = 0; i < 4; i++) push(int'(cmd[i]), (i == 0) ? -1 : H, H, 1);
    if (kind == 1) begin
      for (int i = 0; i < 8; i++) push(0, (i == 0) ? H + C : H, H, 1);
      for (int i = 0; i < 8; i++) push(-1, (i == 0) ? H + C : H, H, 0);
    end else begin
      for (int i = 0; i < 16; i++) push(int'(op[i]), (i == 0) ? H + C : H, H, 1);
      if (kind == 2) begin
        for (int i = 0; i < 3; i++) push(0, H, H, 1);
        push(0, H, P, 1);
        for (int i = 0; i < 16; i++) push(0, (i == 0) ? C : H, H, 1);
      end
    end
  endtask

  function automatic int exp_busy(int kind);
    int bits;
    if (kind == 1) return 2 * H * (4 + 8 + 8) + 3 * C;
    if (kind == 2) begin
      bits = 4 + 16 + 3 + 16;
      return 2 * H * bits + P + 3 * C;
    end
    return 2 * H * 20 + 2 * C;
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one transaction; b2b asks for the inter-transaction low time check
  task automatic run_txn(int kind, logic [3:0] cmd, logic [15:0] op, logic [7:0] tb, bit b2b);
    int n;
    int bad;
    int bad_t;
    int first_lo;
    string req;
    req_kind = 2'(kind);
    req_cmd = cmd;
    req_operand = op;
    req_valid = 1'b1;
    while (!req_ready) tick();
    npulse = 0;
    rdv_cnt = 0;
    rx_idx = 0;
    tgt_byte = tb;
    tick();
    req_valid = 1'b0;
    n = 0;
    while (!req_ready) begin
      n = n + 1;
      tick();
    end
    build_exp(kind, cmd, op);
    first_lo = rec_lo[0];
    // R1 R2 R4 R6: bit pattern
    bad = -1;
    for (int i = 0; i < nexp; i++)
      if (bad < 0 && ((exp_bit[i] >= 0 && rec_bit[i] != exp_bit[i]) || rec_oe[i] != exp_oe[i])) bad = i;
    req = (kind == 1) ? "R1/R4" : (kind == 2) ? "R2/R6" : "R1/R2";
    check(npulse == nexp, req, "pulse count", npulse, nexp);
    check(bad < 0, req, "first bad bit index", bad, -1);
    // R3 R6: timing of every pulse
    bad_t = -1;
    for (int i = 0; i < nexp; i++)
      if (bad_t < 0 && ((exp_lo[i] >= 0 && rec_lo[i] != exp_lo[i]) || rec_hi[i] != exp_hi[i])) bad_t = i;
    check(bad_t < 0, (kind == 2) ? "R3/R6" : "R3", "first bad timing index", bad_t, -1);
    // R7: busy length
    check(n == exp_busy(kind), "R7", "ready-low cycles", n, exp_busy(kind));
    // R5: read strobe
    if (kind == 1) begin
      check(rdv_cnt == 1, "R5", "rd_valid pulses", rdv_cnt, 1);
      check(rdv_data == tb, "R5", "rd_data", int'(rdv_data), int'(tb));
      check(oe_len == 16 * H + C, "R4", "oe low cycles", oe_len, 16 * H + C);
    end else begin
      check(rdv_cnt == 0, "R5", "rd_valid pulses on non-read", rdv_cnt, 0);
    end
    if (b2b) check(first_lo == H + C + 1, "R3", "back-to-back low gap", first_lo, H + C + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit blocked;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check(pin_clk == 1'b0, "R9", "pin_clk in reset", int'(pin_clk), 0);
    check(pin_dat_oe == 1'b1 && pin_dat_out == 1'b0, "R9", "data pin in reset",
          int'({pin_dat_oe, pin_dat_out}), 2);
    check(rd_valid == 1'b0, "R9", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    tick();
    tick();
    check(req_ready == 1'b1 && pin_clk == 1'b0, "R9", "idle after reset",
          int'({req_ready, pin_clk}), 2);

    // R8: tgt_ready low blocks a waiting request
    tgt_ready = 1'b0;
    req_valid = 1'b1;
    req_kind = 2'd0;
    npulse = 0;
    blocked = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (req_ready || pin_clk || !pin_dat_oe) blocked = 1'b0;
    end
    check(blocked, "R8", "no activity while target not ready", int'(blocked), 1);
    check(npulse == 0, "R8", "clock pulses while blocked", npulse, 0);
    req_valid = 1'b0;
    tgt_ready = 1'b1;
    tick();

    // R1 R2: every command code with a walking operand
    for (int k = 0; k < 16; k++) begin
      run_txn(0, 4'(k), 16'h0001 << k, 8'h00, 1'b0);
      tick();
    end
    run_txn(0, 4'hC, 16'hFFFF, 8'h00, 1'b0);
    tick();
    run_txn(3, 4'hD, 16'h12A5, 8'h00, 1'b0);  // R2: kind 3 as write
    tick();

    // R4 R5: reads with walking ones and zeros
    for (int k = 0; k < 8; k++) begin
      run_txn(1, 4'h9, 16'hFFFF, 8'h01 << k, 1'b0);
      tick();
      run_txn(1, 4'h2, 16'h0000, ~(8'h01 << k), 1'b0);
      tick();
    end

    // R6: program-start
    run_txn(2, 4'hF, 16'hBEEF, 8'h00, 1'b0);
    tick();
    run_txn(2, 4'hF, 16'h0000, 8'h00, 1'b0);

    // R3 R7: back-to-back across every kind pairing
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        run_txn(a, 4'(a * 5 + b), 16'h5A3C ^ 16'(b), 8'hC3, 1'b1);
        run_txn(b, 4'(b * 3 + a), 16'hA5C3 ^ 16'(a), 8'h3C, 1'b1);
      end
    end

    repeat (4) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule